// File: doc/BRIEF.md
# Serial DAC Frame Write Controller

This block sits on the host side of a three-wire link to a 24-bit serial digital-to-analog converter. A client hands it one write at a time over a valid/ready handshake: a 16-bit output code and a 2-bit power-mode selector. The block packs these into a 24-bit word. The word carries six leading zero pad bits, then the mode pair, then the code. The block shifts the word out most significant bit first on a frame-select line, a serial clock and a data line, all produced from the system clock.

Between writes the frame-select line rests low to save power on the receiving side. Before every frame it is pulsed high for a programmed number of system clocks, and the frame opens on its falling edge. The serial clock rests low, and data is updated on its rising edges so that it is steady at every falling edge, where the receiver samples it. An abort input cancels a frame in flight. The block raises the frame-select line before the 24th falling edge, which makes the receiver discard the partial word. It then reports the cancel on a flag instead of the completion pulse.

Top module: `dac_frame_writer`

## Requirements
- R1: After reset, ser_sync, ser_clk and ser_dat are 0, req_ready is 1, and wr_done and wr_aborted are 0.
- R2: Each frame carries 24 bits, most significant bit first: bits 23..18 are 0, bits 17..16 are req_mode[1:0], and bits 15..0 are req_code[15:0].
- R3: ser_clk rests low and rises only while ser_sync is low. ser_dat changes only in the cycle in which ser_clk rises, so it is steady at each falling edge.
- R4: When a request is accepted, ser_sync goes high on the acceptance edge and stays high for exactly GAP_CYC system clocks, then falls to open the frame.
- R5: While a frame is shifting, each high phase and each low phase of ser_clk lasts HALF_DIV system clocks. This includes the low phase from the falling edge of ser_sync to the first rising edge.
- R6: ser_sync goes high only on an accepting edge or on an abort edge. After a completed frame it stays low, and req_ready high implies ser_sync and ser_clk both low.
- R7: req_ready is high only when idle. A request is taken on a clock edge where req_valid and req_ready are both high, and req_ready stays low until the frame completes or the abort recovery ends.
- R8: wr_done is a single-cycle pulse, high in the same cycle that ser_clk falls for the 24th time. req_ready is high in that same cycle.
- R9: An abort_req sampled after acceptance and before the 24th falling edge cancels the frame. ser_sync is high from that edge, or stays high if already in the pre-frame gap, and no further falling edge of ser_clk occurs while ser_sync is low. ser_sync falls after GAP_CYC clocks of high level in total. wr_aborted is set and no wr_done is given. The next acceptance clears wr_aborted.
- R10: abort_req has no effect while idle. An abort_req in the same cycle as the 24th falling edge is also ignored, and that frame completes normally.
- R11: req_valid and its data presented while req_ready is low are not taken and produce no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_code | input | 16 | Converter code to send |
| req_mode | input | 2 | Power-mode selector placed in frame bits 17..16 |
| abort_req | input | 1 | Cancel the frame in flight |
| ser_sync | output | 1 | Frame select, low during a transfer |
| ser_clk | output | 1 | Serial clock, rests low |
| ser_dat | output | 1 | Serial data, MSB first |
| wr_done | output | 1 | One-cycle pulse at the 24th falling edge |
| wr_aborted | output | 1 | Set when a frame was cancelled, cleared on the next acceptance |

## Verification
The bench first sends frames with all-zero, all-one and alternating patterns and with each mode pair. It rebuilds every word from the falling edges it observes. A bit slip or swapped fields would show as a mismatched word, and a clock divider off by one as a wrong phase length. Aborts are placed in the pre-frame gap, in a low serial-clock phase, in a high phase, one cycle before the final falling edge, and exactly on it. A design with the wrong priority would either clip a finished frame or let a cancelled frame raise the completion pulse. A design that dropped the serial clock in the same cycle that the frame-select line rose would hand the receiver an extra falling edge. Requests held during a busy frame and aborts raised while idle are also driven. A design that queued the request would emit a stray frame, and one that reacted to the idle abort would pulse the frame-select line.

// File: rtl/dac_wr_pkg.sv
// Shared types for the serial DAC write controller.
// Assumes nothing beyond a single clock domain.
package dac_wr_pkg;

    // Controller sequence states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DRAIN = 2'd3
    } wr_state_t;

endpackage

// File: rtl/dac_frame_pack.sv
// Assembles the serial word: zero padding, then mode bits, then code.
// Purely combinational. Assumes the caller captures the result.
module dac_frame_pack #(
    parameter int CODE_W = 16,
    parameter int MODE_W = 2,
    parameter int PAD_W  = 6,
    localparam int FRAME_W = PAD_W + MODE_W + CODE_W
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [MODE_W-1:0]  mode,
    output logic [FRAME_W-1:0] frame
);

    // Concatenate fields in transmit order, MSB first.
    always_comb begin
        frame = {{PAD_W{1'b0}}, mode, code};
    end

endmodule

// File: rtl/dac_sclk_div.sv
// Produces a one-cycle tick every HALF_DIV system clocks while run is high.
// The count restarts from zero whenever run is low, so the first tick
// comes HALF_DIV clocks after run rises. Assumes HALF_DIV >= 1.
module dac_sclk_div #(
    parameter int HALF_DIV = 5,
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Half-period counter, held at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick on the last count of each half period.
    always_comb begin
        tick = run && (cnt == LAST);
    end

endmodule

// File: rtl/dac_frame_seq.sv
// Frame sequencer: takes one packed word, pulses frame select high for
// GAP_CYC clocks, shifts the word out with data changing on rising serial
// clock edges, and handles cancel requests. Assumes tick comes from a
// divider that runs only while shifting is reported.
module dac_frame_seq
    import dac_wr_pkg::*;
#(
    parameter int FRAME_W = 24,
    parameter int GAP_CYC = 7,
    localparam int GW = $clog2(GAP_CYC + 1),
    localparam int FW = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               abort_req,
    input  logic               tick,
    output logic               idle,
    output logic               shifting,
    output logic               sync_out,
    output logic               sclk_out,
    output logic               sdat_out,
    output logic               done_out,
    output logic               aborted_out
);

    localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_CYC - 1);
    localparam logic [FW-1:0] FALL_LAST = FW'(FRAME_W - 1);

    wr_state_t          state;
    logic [FRAME_W-1:0] shreg;
    logic [GW-1:0]      gap_cnt;
    logic [FW-1:0]      fall_cnt;
    logic               sync_q;
    logic               sclk_q;
    logic               sdat_q;
    logic               done_q;
    logic               abt_q;

    // Main sequence: accept, gap, shift, and cancel recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            gap_cnt  <= '0;
            fall_cnt <= '0;
            sync_q   <= 1'b0;
            sclk_q   <= 1'b0;
            sdat_q   <= 1'b0;
            done_q   <= 1'b0;
            abt_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        shreg   <= frame_in;
                        state   <= ST_GAP;
                        sync_q  <= 1'b1;
                        gap_cnt <= '0;
                        abt_q   <= 1'b0;
                    end
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == GAP_LAST) begin
                        sync_q <= 1'b0;
                        if (abort_req) begin
                            state <= ST_IDLE;
                            abt_q <= 1'b1;
                        end else begin
                            state    <= ST_SHIFT;
                            fall_cnt <= '0;
                        end
                    end else if (abort_req) begin
                        state <= ST_DRAIN;
                        abt_q <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick && sclk_q && (fall_cnt == FALL_LAST)) begin
                        sclk_q <= 1'b0;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (abort_req) begin
                        state   <= ST_DRAIN;
                        sync_q  <= 1'b1;
                        gap_cnt <= '0;
                        abt_q   <= 1'b1;
                    end else if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            sdat_q <= shreg[FRAME_W-1];
                            shreg  <= {shreg[FRAME_W-2:0], 1'b0};
                        end else begin
                            sclk_q   <= 1'b0;
                            fall_cnt <= fall_cnt + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    sclk_q  <= 1'b0;
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == GAP_LAST) begin
                        state  <= ST_IDLE;
                        sync_q <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive outputs from state and registers.
    always_comb begin
        idle        = (state == ST_IDLE);
        shifting    = (state == ST_SHIFT);
        sync_out    = sync_q;
        sclk_out    = sclk_q;
        sdat_out    = sdat_q;
        done_out    = done_q;
        aborted_out = abt_q;
    end

endmodule

// File: rtl/dac_frame_writer.sv
// Top of the serial DAC write controller. Packs a code and a mode pair
// into one word and sends it on a three-wire link with the serial clock
// derived from clk. Assumes HALF_DIV is chosen so that clk/(2*HALF_DIV)
// stays within the receiver's clock limit, and that GAP_CYC clocks cover
// its minimum frame-select high time.
module dac_frame_writer #(
    parameter int CODE_W   = 16,
    parameter int MODE_W   = 2,
    parameter int PAD_W    = 6,
    parameter int HALF_DIV = 5,
    parameter int GAP_CYC  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CODE_W-1:0] req_code,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              abort_req,
    output logic              ser_sync,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              wr_done,
    output logic              wr_aborted
);

    localparam int FRAME_W = PAD_W + MODE_W + CODE_W;

    logic [FRAME_W-1:0] packed_word;
    logic               tick;
    logic               idle;
    logic               shifting;

    dac_frame_pack #(
        .CODE_W(CODE_W),
        .MODE_W(MODE_W),
        .PAD_W (PAD_W)
    ) u_pack (
        .code (req_code),
        .mode (req_mode),
        .frame(packed_word)
    );

    dac_sclk_div #(
        .HALF_DIV(HALF_DIV)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (shifting),
        .tick (tick)
    );

    dac_frame_seq #(
        .FRAME_W(FRAME_W),
        .GAP_CYC(GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req_valid),
        .frame_in   (packed_word),
        .abort_req  (abort_req),
        .tick       (tick),
        .idle       (idle),
        .shifting   (shifting),
        .sync_out   (ser_sync),
        .sclk_out   (ser_clk),
        .sdat_out   (ser_dat),
        .done_out   (wr_done),
        .aborted_out(wr_aborted)
    );

    // Ready whenever the sequencer is idle.
    always_comb begin
        req_ready = idle;
    end

endmodule

// File: rtl/dac_frame_writer_sva.sv
// Property checker for the serial DAC write controller, observing ports only.
// Assumes GAP_CYC matches the bound instance.
module dac_frame_writer_sva #(
    parameter int GAP_CYC = 7
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ser_sync,
    input logic ser_clk,
    input logic ser_dat,
    input logic wr_done,
    input logic wr_aborted
);

    localparam int HW = $clog2(GAP_CYC + 2);
    localparam logic [HW-1:0] HI_MAX = HW'(GAP_CYC + 1);

    logic [HW-1:0] hi_cnt;

    // Count consecutive high cycles of frame select, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_sync) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_MAX) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!ser_sync && !ser_clk && !wr_done));

    p_idle_lines_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ser_sync && !ser_clk));

    p_rise_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> !ser_sync);

    p_data_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dat) |-> $rose(ser_clk));

    p_gap_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_sync) |-> (hi_cnt == HW'(GAP_CYC)));

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && ser_sync));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ($fell(ser_clk) && req_ready));

    p_abort_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_aborted) |-> !wr_done);

endmodule

bind dac_frame_writer dac_frame_writer_sva #(
    .GAP_CYC(GAP_CYC)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ser_sync  (ser_sync),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat),
    .wr_done   (wr_done),
    .wr_aborted(wr_aborted)
);

// File: tb/dac_frame_writer_test.sv
`timescale 1ns/1ps
module dac_frame_writer_test;

    localparam int H    = 5;
    localparam int G    = 7;
    localparam int FULL = G + 48 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_code = '0;
    logic [1:0]  req_mode = '0;
    logic        abort_req = 1'b0;
    logic        ser_sync, ser_clk, ser_dat, wr_done, wr_aborted;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;

    logic [24:0] expq[$];

    always #2.5 clk = ~clk;

    dac_frame_writer #(.HALF_DIV(H), .GAP_CYC(G)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .req_mode(req_mode), .abort_req(abort_req),
        .ser_sync(ser_sync), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .wr_done(wr_done), .wr_aborted(wr_aborted)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor state
    logic        p_sclk = 0, p_sync = 0, p_dat = 0, p_done = 0, p_abf = 0, p_acc = 0, p_abreq = 0;
    int          sclk_run = 0, sync_run = 0, falls = 0;
    logic [23:0] rx = '0;

    // Monitor: rebuilds words from falling edges and scores them.
    always @(negedge clk) begin
        if (mon_en) begin
            if (ser_dat !== p_dat)
                chk(ser_clk && !p_sclk, "R3 data change off rising edge", {31'b0, ser_clk}, 32'd1);
            if (ser_clk && !p_sclk) begin
                chk(!ser_sync, "R3 rise under low sync", {31'b0, ser_sync}, 32'd0);
                chk(sclk_run == H, "R5 low phase length", sclk_run, H);
            end
            if (!ser_clk && p_sclk && !ser_sync) begin
                chk(sclk_run == H, "R5 high phase length", sclk_run, H);
                falls++;
                rx = {rx[22:0], ser_dat};
            end
            if (ser_sync && !p_sync)
                chk(p_acc || p_abreq, "R6 sync rise without cause", {30'b0, p_acc, p_abreq}, 32'd1);
            if (!ser_sync && p_sync)
                chk(sync_run == G, "R4 sync high length", sync_run, G);
            if (wr_done) begin
                logic [24:0] it;
                chk(!p_done, "R8 done wider than one cycle", {31'b0, p_done}, 32'd0);
                chk(falls == 24, "R8 done not at 24th fall", falls, 24);
                chk(req_ready, "R8 ready with done", {31'b0, req_ready}, 32'd1);
                if (expq.size() == 0) begin
                    chk(1'b0, "R11 unexpected frame", {8'b0, rx}, 32'd0);
                end else begin
                    it = expq.pop_front();
                    chk(!it[24], "R9 R10 completed but abort expected", 32'd0, 32'd1);
                    chk(rx == it[23:0], "R2 frame content", {8'b0, rx}, {8'b0, it[23:0]});
                end
            end
            if (wr_aborted && !p_abf) begin
                logic [24:0] it;
                chk(!wr_done, "R9 done with abort", {31'b0, wr_done}, 32'd0);
                chk(falls < 24, "R9 abort after 24 falls", falls, 23);
                if (expq.size() == 0) begin
                    chk(1'b0, "R10 unexpected abort", 32'd1, 32'd0);
                end else begin
                    it = expq.pop_front();
                    chk(it[24], "R9 R10 aborted but completion expected", 32'd1, 32'd0);
                    chk(rx == (it[23:0] >> (24 - falls)), "R9 partial prefix",
                        {8'b0, rx}, {8'b0, it[23:0] >> (24 - falls)});
                end
            end
            if (ser_sync && !p_sync) begin
                falls = 0;
                rx = '0;
            end
        end
        sclk_run = ((ser_clk != p_sclk) || (ser_sync != p_sync)) ? 1 : sclk_run + 1;
        sync_run = (ser_sync != p_sync) ? 1 : sync_run + 1;
        p_sclk = ser_clk; p_sync = ser_sync; p_dat = ser_dat; p_done = wr_done;
        p_abf = wr_aborted; p_acc = req_valid && req_ready; p_abreq = abort_req;
    end

    // Driver: pushes the expected result, issues the request and optional abort/noise.
    task automatic send(input logic [15:0] code, input logic [1:0] mode, input int abort_k, input bit noise);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_code = code; req_mode = mode; req_valid = 1'b1;
        expq.push_back({(abort_k > 0 && abort_k < FULL), 6'b0, mode, code});
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R7 ready low after accept", {31'b0, req_ready}, 32'd0);
        chk(ser_sync, "R4 sync high after accept", {31'b0, ser_sync}, 32'd1);
        chk(!wr_aborted, "R9 flag cleared on accept", {31'b0, wr_aborted}, 32'd0);
        if (noise) begin
            req_valid = 1'b1; req_code = ~code; req_mode = ~mode;
            repeat (30) @(negedge clk);
            req_valid = 1'b0;
        end else if (abort_k > 0) begin
            repeat (abort_k - 1) @(negedge clk);
            abort_req = 1'b1;
            @(negedge clk);
            abort_req = 1'b0;
        end
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!ser_sync && !ser_clk && !ser_dat, "R1 lines after reset",
            {29'b0, ser_sync, ser_clk, ser_dat}, 32'd0);
        chk(req_ready && !wr_done && !wr_aborted, "R1 status after reset",
            {29'b0, req_ready, wr_done, wr_aborted}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        // R2 varied patterns and modes
        send(16'hA5C3, 2'b00, 0, 0);
        send(16'hFFFF, 2'b11, 0, 0);
        send(16'h0001, 2'b01, 0, 0);
        send(16'h8000, 2'b10, 0, 0);
        send(16'h0000, 2'b00, 0, 0);
        // R9 aborts: in gap, low phase, high phase, one before last fall
        send(16'h1234, 2'b01, 2, 0);
        send(16'h5A5A, 2'b10, G + 10 * H + 2, 0);
        send(16'hC3C3, 2'b11, G + 21 * H + 1, 0);
        send(16'hBEEF, 2'b01, FULL - 1, 0);
        send(16'h0F0F, 2'b00, G, 0);
        // R10 abort coinciding with last fall
        send(16'h7E81, 2'b10, FULL, 0);
        chk(!wr_aborted, "R10 flag clear after late abort", {31'b0, wr_aborted}, 32'd0);
        // R10 abort while idle
        abort_req = 1'b1;
        repeat (3) @(negedge clk);
        abort_req = 1'b0;
        repeat (G + 2) begin
            @(negedge clk);
            chk(!ser_sync && !wr_aborted && req_ready, "R10 idle abort ignored",
                {29'b0, ser_sync, wr_aborted, req_ready}, 32'd1);
        end
        // R11 request held while busy
        send(16'h3C5A, 2'b01, 0, 1);
        repeat (3 * FULL) @(negedge clk);
        chk(expq.size() == 0, "R11 scoreboard drained", expq.size(), 32'd0);
        chk(req_ready && !ser_sync, "R6 idle at end", {30'b0, req_ready, ser_sync}, 32'd2);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule